// File: doc/BRIEF.md
# External Bus Write Sequencer with Ready Stretch

This block carries out single write accesses on an external asynchronous memory bus for an on-chip master. The master raises a request with an address and a data word; the block captures both and plays out one access in three timed phases (lead, active and trail), each measured in cycles of the bus-timing clock. During the access it drives an active-low chip-select, an active-low write strobe, a read/not-write line, the address bus and a data bus with a separate output enable, so that a pad cell can make it tri-state. When the trail phase completes, it returns a one-cycle acknowledge.

A ready input from the external device can hold the access in its active phase. A mode input selects how ready is treated. It can be ignored, so that only the fixed wait states apply. It can be registered once as a synchronous signal. Or it can pass through a two-flop synchronizer and then be sampled, as an asynchronous signal. In asynchronous mode the pin is effectively looked at two cycles earlier than in synchronous mode, which hides the synchronizer latency. The phase lengths and the ready mode are captured together with the request. The address bus keeps its last value between accesses.

Top module: `xbus_wr_seq`

## Requirements
- R1: After reset, chip-select, write strobe and read/not-write are high, the data enable and ack are low, and the address bus is zero. While no access runs, the address bus keeps the last address driven.
- R2: A request accepted while idle captures the address, the data, the phase lengths and the ready mode. Changes on the request inputs during the access have no effect on the bus.
- R3: The lead phase drives chip-select and read/not-write low, keeps the write strobe high and the data bus undriven, and lasts the lead count in cycles. A lead count of 0 is treated as 1.
- R4: In the active phase the write strobe is low and the captured data is driven. With ready mode code 0 (ignore; code 3 also acts as ignore), the phase lasts exactly the active count (minimum 1).
- R5: With ready mode code 1 (synchronous), ready is registered once. The active phase ends at the first cycle c, counted from 1, with c at least the active count and the pin high at the end of cycle c-1. Ready that first rises during active cycle R gives max(active, R+1) active cycles.
- R6: With ready mode code 2 (asynchronous), ready passes two synchronizer flops and one sample flop, so the pin is consulted two cycles earlier than in R5. Ready that first rises during active cycle R gives max(active, R+3) cycles. The active count has a minimum of 2.
- R7: The trail phase keeps chip-select and read/not-write low, the write strobe high and the data driven and valid. It lasts the trail count in cycles, and a trail count of 0 is treated as 1.
- R8: Ack is high for exactly one cycle per access: the last trail cycle.
- R9: In the cycle after the trail phase, chip-select and read/not-write are high while the data bus is still driven. The driver is released in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus-timing clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_lead | input | CW | Lead phase length in cycles |
| cfg_active | input | CW | Minimum active phase length in cycles |
| cfg_trail | input | CW | Trail phase length in cycles |
| cfg_rdy_mode | input | 2 | 0 ignore, 1 synchronous, 2 asynchronous, 3 ignore |
| req | input | 1 | Write request from the master |
| req_addr | input | AW | Write address |
| req_data | input | DW | Write data |
| ack | output | 1 | One-cycle completion pulse |
| bus_cs_n | output | 1 | Chip-select, active low |
| bus_we_n | output | 1 | Write strobe, active low |
| bus_rnw | output | 1 | Read/not-write line |
| bus_addr | output | AW | External address bus |
| bus_data_o | output | DW | External data bus value |
| bus_data_oe | output | 1 | Data bus output enable |
| bus_rdy | input | 1 | Ready from the external device |

## Verification
The assertions take for granted that the master holds req low until ack, or drops it in the cycle after acceptance. They also take for granted that configuration values lie within the counter width. For each access the stimulus raises req for a single cycle. It drives ready low at every access end and then waits several idle cycles, so that no stale high value is still in the three-flop asynchronous path when the next access starts. Ready is raised only once per access, at a chosen active cycle, and held until the access ends. This keeps the stretch length of R5 and R6 exactly predictable.

// File: rtl/xbw_pkg.sv
package xbw_pkg;
   typedef enum logic [1:0] {
      PH_IDLE   = 2'd0,
      PH_LEAD   = 2'd1,
      PH_ACTIVE = 2'd2,
      PH_TRAIL  = 2'd3
   } phase_e;

   typedef enum logic [1:0] {
      RDY_IGNORE = 2'd0,
      RDY_SYNC   = 2'd1,
      RDY_ASYNC  = 2'd2,
      RDY_RSVD   = 2'd3
   } rdy_mode_e;
endpackage

// File: rtl/xbw_rdy_path.sv
// Ready conditioning: one register for the synchronous path, a synchronizer
// chain plus a sample register for the asynchronous path.
module xbw_rdy_path #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rdy_pin,
   output logic rdy_sync_q,
   output logic rdy_async_q
);
   localparam int CHAIN = SYNC_STAGES + 1;

   if (SYNC_STAGES < 2) begin : g_bad_stages
      $error("xbw_rdy_path: SYNC_STAGES must be at least 2");
   end

   logic [CHAIN-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rdy_sync_q <= 1'b0;
      else        rdy_sync_q <= rdy_pin;
   end

   for (genvar s = 0; s < CHAIN; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[0] <= 1'b0;
            else        chain_q[0] <= rdy_pin;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= 1'b0;
            else        chain_q[s] <= chain_q[s-1];
         end
      end
   end

   assign rdy_async_q = chain_q[CHAIN-1];
endmodule

// File: rtl/xbw_phase_ctl.sv
// Phase sequencer: one shared counter, restarted at every phase entry.
module xbw_phase_ctl
   import xbw_pkg::*;
#(
   parameter int CW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [CW-1:0] lead_len,
   input  logic [CW-1:0] act_len,
   input  logic [CW-1:0] trail_len,
   input  logic          rdy_ok,
   output phase_e        phase,
   output logic          last_trail
);
   localparam logic [CW-1:0] CNT_ONE = CW'(1);
   localparam logic [CW-1:0] CNT_MAX = '1;

   logic [CW-1:0] cnt_q, cnt_d;
   phase_e        phase_d;

   always_comb begin
      phase_d    = phase;
      cnt_d      = cnt_q;
      last_trail = 1'b0;
      unique case (phase)
         PH_IDLE: begin
            if (start) begin
               phase_d = PH_LEAD;
               cnt_d   = CNT_ONE;
            end
         end
         PH_LEAD: begin
            if (cnt_q >= lead_len) begin
               phase_d = PH_ACTIVE;
               cnt_d   = CNT_ONE;
            end else begin
               cnt_d = cnt_q + CNT_ONE;
            end
         end
         PH_ACTIVE: begin
            if ((cnt_q >= act_len) && rdy_ok) begin
               phase_d = PH_TRAIL;
               cnt_d   = CNT_ONE;
            end else if (cnt_q != CNT_MAX) begin
               cnt_d = cnt_q + CNT_ONE;
            end
         end
         PH_TRAIL: begin
            if (cnt_q >= trail_len) begin
               phase_d    = PH_IDLE;
               last_trail = 1'b1;
            end else begin
               cnt_d = cnt_q + CNT_ONE;
            end
         end
         default: phase_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         cnt_q <= CNT_ONE;
      end else begin
         phase <= phase_d;
         cnt_q <= cnt_d;
      end
   end
endmodule

// File: rtl/xbus_wr_seq.sv
module xbus_wr_seq
   import xbw_pkg::*;
#(
   parameter int AW          = 16,
   parameter int DW          = 16,
   parameter int CW          = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [CW-1:0] cfg_lead,
   input  logic [CW-1:0] cfg_active,
   input  logic [CW-1:0] cfg_trail,
   input  logic [1:0]    cfg_rdy_mode,
   input  logic          req,
   input  logic [AW-1:0] req_addr,
   input  logic [DW-1:0] req_data,
   output logic          ack,
   output logic          bus_cs_n,
   output logic          bus_we_n,
   output logic          bus_rnw,
   output logic [AW-1:0] bus_addr,
   output logic [DW-1:0] bus_data_o,
   output logic          bus_data_oe,
   input  logic          bus_rdy
);
   localparam logic [CW-1:0] MIN_ONE = CW'(1);
   localparam logic [CW-1:0] MIN_TWO = CW'(2);

   if (CW < 2 || CW > 8) begin : g_bad_cw
      $error("xbus_wr_seq: CW must lie in 2..8");
   end
   if (AW < 1 || DW < 1) begin : g_bad_widths
      $error("xbus_wr_seq: AW and DW must be positive");
   end

   phase_e        phase;
   logic          start, last_trail, hold_q, rdy_ok;
   logic          rdy_sync_q, rdy_async_q;
   logic [AW-1:0] addr_q;
   logic [DW-1:0] data_q;
   logic [CW-1:0] lead_q, act_q, trail_q;
   logic [CW-1:0] lead_min, act_min, trail_min;
   rdy_mode_e     mode_in, mode_q;

   assign start   = (phase == PH_IDLE) && req;
   assign mode_in = rdy_mode_e'(cfg_rdy_mode);

   // Clamp the programmed lengths to their minimums at capture time.
   always_comb begin
      lead_min  = (cfg_lead  < MIN_ONE) ? MIN_ONE : cfg_lead;
      trail_min = (cfg_trail < MIN_ONE) ? MIN_ONE : cfg_trail;
      if (mode_in == RDY_ASYNC)
         act_min = (cfg_active < MIN_TWO) ? MIN_TWO : cfg_active;
      else
         act_min = (cfg_active < MIN_ONE) ? MIN_ONE : cfg_active;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         data_q  <= '0;
         lead_q  <= MIN_ONE;
         act_q   <= MIN_ONE;
         trail_q <= MIN_ONE;
         mode_q  <= RDY_IGNORE;
      end else if (start) begin
         addr_q  <= req_addr;
         data_q  <= req_data;
         lead_q  <= lead_min;
         act_q   <= act_min;
         trail_q <= trail_min;
         mode_q  <= mode_in;
      end
   end

   xbw_rdy_path #(.SYNC_STAGES(SYNC_STAGES)) u_rdy (
      .clk         (clk),
      .rst_n       (rst_n),
      .rdy_pin     (bus_rdy),
      .rdy_sync_q  (rdy_sync_q),
      .rdy_async_q (rdy_async_q)
   );

   always_comb begin
      unique case (mode_q)
         RDY_SYNC:  rdy_ok = rdy_sync_q;
         RDY_ASYNC: rdy_ok = rdy_async_q;
         default:   rdy_ok = 1'b1;
      endcase
   end

   xbw_phase_ctl #(.CW(CW)) u_phase (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .lead_len   (lead_q),
      .act_len    (act_q),
      .trail_len  (trail_q),
      .rdy_ok     (rdy_ok),
      .phase      (phase),
      .last_trail (last_trail)
   );

   // Keep the data driver on for one cycle after read/not-write returns high.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hold_q <= 1'b0;
      else        hold_q <= last_trail;
   end

   assign bus_cs_n    = (phase == PH_IDLE);
   assign bus_rnw     = (phase == PH_IDLE);
   assign bus_we_n    = (phase != PH_ACTIVE);
   assign bus_data_oe = (phase == PH_ACTIVE) || (phase == PH_TRAIL) || hold_q;
   assign bus_addr    = addr_q;
   assign bus_data_o  = data_q;
   assign ack         = last_trail;
endmodule

// File: rtl/xbw_checker.sv
module xbw_checker #(
   parameter int AW = 16,
   parameter int DW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          ack,
   input logic          bus_cs_n,
   input logic          bus_we_n,
   input logic          bus_rnw,
   input logic [AW-1:0] bus_addr,
   input logic [DW-1:0] bus_data_o,
   input logic          bus_data_oe
);
   a_r1_addr_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      bus_cs_n |-> $stable(bus_addr));

   a_r2_addr_stable_in_access: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_cs_n && $past(!bus_cs_n)) |-> $stable(bus_addr));

   a_r4_strobe_inside_select: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_we_n |-> (!bus_cs_n && !bus_rnw && bus_data_oe));

   a_r7_data_stable_while_driven: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_data_oe && $past(bus_data_oe)) |-> $stable(bus_data_o));

   a_r3_no_drive_on_select: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bus_cs_n) |-> (!bus_data_oe && bus_we_n));

   a_r8_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
      ack |=> !ack);

   a_r8_ack_in_trail: assert property (@(posedge clk) disable iff (!rst_n)
      ack |-> (!bus_cs_n && bus_we_n && bus_data_oe));

   a_r9_release_after_rnw: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_rnw) |-> (bus_data_oe ##1 !bus_data_oe));

   a_r9_ack_ends_access: assert property (@(posedge clk) disable iff (!rst_n)
      ack |=> (bus_cs_n && bus_rnw));
endmodule

bind xbus_wr_seq xbw_checker #(.AW(AW), .DW(DW)) u_xbw_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .ack         (ack),
   .bus_cs_n    (bus_cs_n),
   .bus_we_n    (bus_we_n),
   .bus_rnw     (bus_rnw),
   .bus_addr    (bus_addr),
   .bus_data_o  (bus_data_o),
   .bus_data_oe (bus_data_oe)
);

// File: tb/test_xbus_wr_seq.sv
`timescale 1ns/1ps
module test_xbus_wr_seq;
   localparam int AW = 16;
   localparam int DW = 16;
   localparam int CW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [CW-1:0] cfg_lead = '0, cfg_active = '0, cfg_trail = '0;
   logic [1:0]    cfg_rdy_mode = '0;
   logic          req = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_data = '0;
   logic          ack, bus_cs_n, bus_we_n, bus_rnw, bus_data_oe;
   logic [AW-1:0] bus_addr;
   logic [DW-1:0] bus_data_o;
   logic          bus_rdy = 1'b0;

   int n_tests = 0;
   int n_fail  = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   xbus_wr_seq #(.AW(AW), .DW(DW), .CW(CW)) i_xbus_wr_seq (
      .clk, .rst_n, .cfg_lead, .cfg_active, .cfg_trail, .cfg_rdy_mode,
      .req, .req_addr, .req_data, .ack, .bus_cs_n, .bus_we_n, .bus_rnw,
      .bus_addr, .bus_data_o, .bus_data_oe, .bus_rdy
   );

   typedef struct packed {
      logic [3:0]  lead, act, trail;
      logic [1:0]  mode;
      logic [3:0]  rdy_at;     // 0: ready high from the request on
      logic [15:0] addr, data;
      logic [3:0]  exp_lead, exp_act, exp_trail;
   } vec_t;

   localparam int NV = 10;
   localparam vec_t VECS [NV] = '{
      '{4'd1, 4'd1, 4'd1, 2'd0, 4'd0, 16'h1234, 16'hA5A5, 4'd1, 4'd1, 4'd1},
      '{4'd3, 4'd4, 4'd2, 2'd0, 4'd0, 16'h0F0F, 16'h5A5A, 4'd3, 4'd4, 4'd2},
      '{4'd2, 4'd3, 4'd2, 2'd1, 4'd0, 16'h8001, 16'h00FF, 4'd2, 4'd3, 4'd2},
      '{4'd1, 4'd2, 4'd1, 2'd1, 4'd5, 16'h4444, 16'hFF00, 4'd1, 4'd6, 4'd1},
      '{4'd2, 4'd6, 4'd3, 2'd1, 4'd2, 16'h2222, 16'h1357, 4'd2, 4'd6, 4'd3},
      '{4'd1, 4'd2, 4'd2, 2'd2, 4'd0, 16'hBEEF, 16'hCAFE, 4'd1, 4'd2, 4'd2},
      '{4'd2, 4'd3, 4'd1, 2'd2, 4'd4, 16'h7777, 16'h2468, 4'd2, 4'd7, 4'd1},
      '{4'd1, 4'd5, 4'd2, 2'd2, 4'd1, 16'h0101, 16'h9999, 4'd1, 4'd5, 4'd2},
      '{4'd0, 4'd1, 4'd0, 2'd2, 4'd0, 16'h3C3C, 16'hC3C3, 4'd1, 4'd2, 4'd1},
      '{4'd0, 4'd0, 4'd0, 2'd3, 4'd9, 16'hFFFF, 16'h0001, 4'd1, 4'd1, 4'd1}
   };

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic string mode_tag(input logic [1:0] m);
      if (m == 2'd1) return "R5 sync active length";
      if (m == 2'd2) return "R6 async active length";
      return "R4 fixed active length";
   endfunction

   task automatic run_vec(input vec_t v);
      int  nl = 0, na = 0, nt = 0, nack = 0, ack_at = 0, guard = 0;
      bit  seen_act = 1'b0, done = 1'b0;
      @(negedge clk);
      cfg_lead = v.lead; cfg_active = v.act; cfg_trail = v.trail; cfg_rdy_mode = v.mode;
      req = 1'b1; req_addr = v.addr; req_data = v.data;
      bus_rdy = (v.rdy_at == 4'd0);
      @(negedge clk);
      req = 1'b0; req_addr = ~v.addr; req_data = ~v.data;
      cfg_lead = 4'd9; cfg_active = 4'd9; cfg_trail = 4'd9; cfg_rdy_mode = 2'd1;
      while (!done && guard < 200) begin
         guard++;
         if (!bus_cs_n) begin
            chk(bus_addr == v.addr, "R2 captured address", 32'(bus_addr), 32'(v.addr));
            if (!bus_we_n) begin
               na++; seen_act = 1'b1;
               chk(bus_data_oe && bus_data_o == v.data && !bus_rnw, "R4 active drive",
                   32'(bus_data_o), 32'(v.data));
               if (v.mode != 2'd0 && v.mode != 2'd3 && na == int'(v.rdy_at)) bus_rdy = 1'b1;
            end else if (!seen_act) begin
               nl++;
               chk(!bus_data_oe && !bus_rnw, "R3 lead signals", {30'd0, bus_data_oe, bus_rnw}, 32'd0);
            end else begin
               nt++;
               chk(bus_data_oe && bus_data_o == v.data && !bus_rnw, "R7 trail data",
                   32'(bus_data_o), 32'(v.data));
            end
            if (ack) begin nack++; ack_at = nt; end
         end else begin
            done = 1'b1;
            chk(bus_rnw && bus_data_oe && bus_data_o == v.data, "R9 hold after rnw high",
                {30'd0, bus_rnw, bus_data_oe}, 32'd3);
         end
         if (!done) @(negedge clk);
      end
      chk(done, "R4 watchdog access end", 32'(guard), 32'd200);
      chk(nl == int'(v.exp_lead), "R3 lead length", 32'(nl), 32'(v.exp_lead));
      chk(na == int'(v.exp_act), mode_tag(v.mode), 32'(na), 32'(v.exp_act));
      chk(nt == int'(v.exp_trail), "R7 trail length", 32'(nt), 32'(v.exp_trail));
      chk(nack == 1 && ack_at == nt, "R8 single ack on last trail", 32'(nack * 16 + ack_at), 32'(16 + nt));
      bus_rdy = 1'b0;
      @(negedge clk);
      chk(!bus_data_oe, "R9 release", {31'd0, bus_data_oe}, 32'd0);
      for (int k = 0; k < 4; k++) begin
         if (k > 0) @(negedge clk);
         chk(bus_cs_n && bus_addr == v.addr && !ack, "R1 idle address hold",
             32'(bus_addr), 32'(v.addr));
      end
   endtask

   initial begin
      #2_000_000;
      if (!finished) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(bus_cs_n && bus_we_n && bus_rnw, "R1 reset strobes high",
          {29'd0, bus_cs_n, bus_we_n, bus_rnw}, 32'd7);
      chk(!bus_data_oe && !ack, "R1 reset no drive or ack", {30'd0, bus_data_oe, ack}, 32'd0);
      chk(bus_addr == '0, "R1 reset address zero", 32'(bus_addr), 32'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(bus_cs_n && !bus_data_oe, "R1 idle after reset", {30'd0, bus_cs_n, bus_data_oe}, 32'd2);

      for (int i = 0; i < NV; i++) run_vec(VECS[i]);

      // R2 directed: request inputs toggling while idle with req low start nothing
      @(negedge clk);
      req_addr = 16'hDEAD; req_data = 16'hF00D;
      repeat (3) @(negedge clk);
      chk(bus_cs_n && bus_addr == 16'hFFFF, "R2 no request no access", 32'(bus_addr), 32'hFFFF);

      // R1 directed: reset in idle clears the address again
      rst_n = 1'b0;
      @(negedge clk);
      chk(bus_addr == '0 && bus_cs_n, "R1 address zero after reset", 32'(bus_addr), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule